// File: doc/BRIEF.md
# Base-Delta Compressed Translation Buffer

A set-associative second-level buffer that maps virtual page numbers to physical page numbers. Each set has two halves. The plain half keeps full page-number pairs. The packed half keeps only the low-order parts of each pair. Each set also has two base registers, one virtual and one physical, that hold the high-order bits shared by every packed entry in that set. Because a packed entry is narrow, each packed slot holds two translations. This lets the set hold more translations when accesses cluster in one region of the address space.

A translation walker supplies new pairs on the insert port. A pair goes to the packed half when both its virtual and physical high parts equal the set's bases; otherwise it goes to the plain half. Each half evicts only its own entries, in round-robin order. A per-set countdown counts inserts that could not be packed. When it runs out, the set drops all of its packed entries and forgets its bases. The next insert into that set then sets up new bases, so the bases follow the region that is currently in use. Lookups return their result one cycle after the request.

Top module: `bdc_tlb`

## Requirements
- R1: After reset, every lookup misses and returns a physical page number of zero.
- R2: `respValid` is high exactly in the cycle after a cycle with `lookupValid` high, and `respHit` is never high without `respValid`. The result reflects every insert accepted before the lookup cycle.
- R3: The set is selected by virtual page bits [4:0] (32 sets), and inserts into one set never change the contents or bases of another set.
- R4: An insert into a set with no installed base loads the virtual base from virtual bits [30:13] and the physical base from physical bits [18:9]. It then stores the pair in the packed half and reloads the countdown.
- R5: An insert is packed only when its virtual bits [30:13] equal the set's virtual base and its physical bits [18:9] equal the set's physical base. A mismatch in either one places it in the plain half.
- R6: Each insert that is placed in the plain half decrements the set's countdown by one, and an idle insert port changes nothing.
- R7: The plain half has 4 entries per set, replaced round-robin: the fifth plain insert into a set evicts the first.
- R8: The packed half has 4 slots of two entries, 8 translations per set, replaced round-robin: the ninth packed insert evicts the first. Packed inserts never evict plain entries, and plain inserts never evict packed entries.
- R9: The countdown starts at 8. On the eighth plain insert after a base was installed, all packed entries of the set are invalidated and its base is cleared. The next insert installs a new base.
- R10: A hit in either half returns the stored physical page number. For a packed entry, the returned number is the physical base joined with the stored low part, with the virtual match made on the virtual base joined with the stored low part. A miss returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Lookup request strobe |
| lookupVpn | input | 31 | Virtual page number to translate |
| respValid | output | 1 | Lookup result valid, one cycle after the request |
| respHit | output | 1 | Translation found |
| respPpn | output | 19 | Physical page number on a hit, zero on a miss |
| insValid | input | 1 | Insert strobe from the walker |
| insVpn | input | 31 | Virtual page number to insert |
| insPpn | input | 19 | Physical page number to insert |

## Verification
The bench targets the following corner cases, and what a faulty design would do in each:
- A pair whose virtual high part matches the base but whose physical high part does not. A design that compares only the virtual side would pack it, and the lookup would return the wrong physical page.
- The ninth packed insert and the fifth plain insert. Here a wrong pointer width or a shared pointer shows up as the wrong entry missing.
- A plain insert made while the packed half is full. A design that evicts across halves would lose a packed entry here.
- The seventh and eighth plain inserts after a base install. An off-by-one countdown would flush one insert early or late.
- The first insert after a flush. A design that does not reload the base or restart the counter would fail to pack it.

// File: rtl/bdc_tlb_pkg.sv
package bdc_tlb_pkg;
  typedef struct packed {
    logic loadBase;   // install new virtual and physical bases
    logic wrComp;     // write into the packed half
    logic wrUnc;      // write into the plain half
    logic flushComp;  // drop every packed entry and the base
  } tlbStrobe_t;
endpackage

// File: rtl/bdc_tlb_ctrl.sv
module bdc_tlb_ctrl
  import bdc_tlb_pkg::*;
#(
  parameter int SET_W = 5,
  parameter int REBASE_INIT = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             insValid,
  input  logic [SET_W-1:0] insSet,
  input  logic             baseMatch,
  output tlbStrobe_t       strb
);
  localparam int SETS  = 1 << SET_W;
  localparam int CNT_W = $clog2(REBASE_INIT + 1);

  logic             baseValid [SETS];
  logic [CNT_W-1:0] rebaseCnt [SETS];

  always_comb begin
    strb = '0;
    if (insValid) begin
      if (!baseValid[insSet]) begin
        strb.loadBase = 1'b1;
        strb.wrComp   = 1'b1;
      end else if (baseMatch) begin
        strb.wrComp = 1'b1;
      end else begin
        strb.wrUnc     = 1'b1;
        strb.flushComp = (rebaseCnt[insSet] == CNT_W'(1));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        baseValid[s] <= 1'b0;
        rebaseCnt[s] <= '0;
      end
    end else begin
      if (strb.loadBase) begin
        baseValid[insSet] <= 1'b1;
        rebaseCnt[insSet] <= CNT_W'(REBASE_INIT);
      end else if (strb.wrUnc) begin
        rebaseCnt[insSet] <= rebaseCnt[insSet] - CNT_W'(1);
        if (strb.flushComp) baseValid[insSet] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bdc_tlb_dp.sv
module bdc_tlb_dp
  import bdc_tlb_pkg::*;
#(
  parameter int VPN_W   = 31,
  parameter int PPN_W   = 19,
  parameter int SET_W   = 5,
  parameter int VD_W    = 13,
  parameter int PD_W    = 9,
  parameter int U_WAYS  = 4,
  parameter int C_SLOTS = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  tlbStrobe_t       strb,
  input  logic [VPN_W-1:0] insVpn,
  input  logic [PPN_W-1:0] insPpn,
  output logic             baseMatch,
  input  logic             lookupValid,
  input  logic [VPN_W-1:0] lookupVpn,
  output logic             respValid,
  output logic             respHit,
  output logic [PPN_W-1:0] respPpn
);
  localparam int SETS  = 1 << SET_W;
  localparam int C_ENT = 2 * C_SLOTS;   // two packed entries per slot
  localparam int VB_W  = VPN_W - VD_W;
  localparam int PB_W  = PPN_W - PD_W;
  localparam int UP_W  = $clog2(U_WAYS);
  localparam int CP_W  = $clog2(C_ENT);

  logic [VPN_W-1:0] uVpn [SETS][U_WAYS];
  logic [PPN_W-1:0] uPpn [SETS][U_WAYS];
  logic             uVal [SETS][U_WAYS];
  logic [VD_W-1:0]  cVd  [SETS][C_ENT];
  logic [PD_W-1:0]  cPd  [SETS][C_ENT];
  logic             cVal [SETS][C_ENT];
  logic [VB_W-1:0]  vBase [SETS];
  logic [PB_W-1:0]  pBase [SETS];
  logic [UP_W-1:0]  uPtr [SETS];
  logic [CP_W-1:0]  cPtr [SETS];

  logic [SET_W-1:0] iSet, lkSet;
  logic             lkHit;
  logic [PPN_W-1:0] lkPpn;

  assign iSet  = insVpn[SET_W-1:0];
  assign lkSet = lookupVpn[SET_W-1:0];
  assign baseMatch = (insVpn[VPN_W-1:VD_W] == vBase[iSet]) &&
                     (insPpn[PPN_W-1:PD_W] == pBase[iSet]);

  always_comb begin
    lkHit = 1'b0;
    lkPpn = '0;
    for (int u = 0; u < U_WAYS; u++) begin
      if (uVal[lkSet][u] && uVpn[lkSet][u] == lookupVpn) begin
        lkHit = 1'b1;
        lkPpn = uPpn[lkSet][u];
      end
    end
    for (int e = 0; e < C_ENT; e++) begin
      if (cVal[lkSet][e] && {vBase[lkSet], cVd[lkSet][e]} == lookupVpn) begin
        lkHit = 1'b1;
        lkPpn = {pBase[lkSet], cPd[lkSet][e]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        for (int u = 0; u < U_WAYS; u++) begin
          uVpn[s][u] <= '0;
          uPpn[s][u] <= '0;
          uVal[s][u] <= 1'b0;
        end
        for (int e = 0; e < C_ENT; e++) begin
          cVd[s][e]  <= '0;
          cPd[s][e]  <= '0;
          cVal[s][e] <= 1'b0;
        end
        vBase[s] <= '0;
        pBase[s] <= '0;
        uPtr[s]  <= '0;
        cPtr[s]  <= '0;
      end
      respValid <= 1'b0;
      respHit   <= 1'b0;
      respPpn   <= '0;
    end else begin
      if (strb.loadBase) begin
        vBase[iSet] <= insVpn[VPN_W-1:VD_W];
        pBase[iSet] <= insPpn[PPN_W-1:PD_W];
      end
      if (strb.wrComp) begin
        cVd[iSet][cPtr[iSet]]  <= insVpn[VD_W-1:0];
        cPd[iSet][cPtr[iSet]]  <= insPpn[PD_W-1:0];
        cVal[iSet][cPtr[iSet]] <= 1'b1;
        cPtr[iSet] <= cPtr[iSet] + CP_W'(1);
      end
      if (strb.wrUnc) begin
        uVpn[iSet][uPtr[iSet]] <= insVpn;
        uPpn[iSet][uPtr[iSet]] <= insPpn;
        uVal[iSet][uPtr[iSet]] <= 1'b1;
        uPtr[iSet] <= uPtr[iSet] + UP_W'(1);
      end
      if (strb.flushComp) begin
        for (int e = 0; e < C_ENT; e++) cVal[iSet][e] <= 1'b0;
        cPtr[iSet] <= '0;
      end
      respValid <= lookupValid;
      respHit   <= lookupValid && lkHit;
      respPpn   <= (lookupValid && lkHit) ? lkPpn : '0;
    end
  end
endmodule

// File: rtl/bdc_tlb.sv
module bdc_tlb
  import bdc_tlb_pkg::*;
#(
  parameter int VPN_W       = 31,
  parameter int PPN_W       = 19,
  parameter int SET_W       = 5,
  parameter int VD_W        = 13,
  parameter int PD_W        = 9,
  parameter int U_WAYS      = 4,
  parameter int C_SLOTS     = 4,
  parameter int REBASE_INIT = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic [VPN_W-1:0] lookupVpn,
  output logic             respValid,
  output logic             respHit,
  output logic [PPN_W-1:0] respPpn,
  input  logic             insValid,
  input  logic [VPN_W-1:0] insVpn,
  input  logic [PPN_W-1:0] insPpn
);
  tlbStrobe_t strb;
  logic       baseMatch;

  bdc_tlb_ctrl #(.SET_W(SET_W), .REBASE_INIT(REBASE_INIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .insValid(insValid),
    .insSet(insVpn[SET_W-1:0]), .baseMatch(baseMatch), .strb(strb)
  );

  bdc_tlb_dp #(
    .VPN_W(VPN_W), .PPN_W(PPN_W), .SET_W(SET_W), .VD_W(VD_W),
    .PD_W(PD_W), .U_WAYS(U_WAYS), .C_SLOTS(C_SLOTS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .insVpn(insVpn), .insPpn(insPpn),
    .baseMatch(baseMatch), .lookupValid(lookupValid), .lookupVpn(lookupVpn),
    .respValid(respValid), .respHit(respHit), .respPpn(respPpn)
  );
endmodule

// File: rtl/bdc_tlb_chk.sv
module bdc_tlb_chk
  import bdc_tlb_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       lookupValid,
  input logic       respValid,
  input logic       respHit,
  input logic       insValid,
  input tlbStrobe_t strb
);
  assert_resp_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (respValid == $past(lookupValid)));

  assert_hit_qualified_R2: assert property (@(posedge clk) disable iff (!rstN)
    respHit |-> respValid);

  assert_single_half_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrComp, strb.wrUnc}));

  assert_base_packs_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadBase |-> strb.wrComp);

  assert_flush_on_plain_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.flushComp |-> strb.wrUnc);

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    !insValid |-> (strb == '0));
endmodule

bind bdc_tlb bdc_tlb_chk u_chk (
  .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .respValid(respValid),
  .respHit(respHit), .insValid(insValid), .strb(strb)
);

// File: tb/sim_bdc_tlb.sv
`timescale 1ns/1ps
module sim_bdc_tlb;
  localparam int INIT = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lookupValid = 1'b0;
  logic [30:0] lookupVpn = '0;
  logic        respValid, respHit;
  logic [18:0] respPpn;
  logic        insValid = 1'b0;
  logic [30:0] insVpn = '0;
  logic [18:0] insPpn = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bdc_tlb u0 (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupVpn(lookupVpn),
    .respValid(respValid), .respHit(respHit), .respPpn(respPpn),
    .insValid(insValid), .insVpn(insVpn), .insPpn(insPpn)
  );

  // Expected-state model built from the requirements
  bit          mBV  [32];
  logic [17:0] mVB  [32];
  logic [9:0]  mPB  [32];
  int          mCnt [32];
  logic [30:0] mUV  [32][4];
  logic [18:0] mUP  [32][4];
  bit          mUVal[32][4];
  int          mUPtr[32];
  logic [30:0] mCV  [32][8];
  logic [18:0] mCP  [32][8];
  bit          mCVal[32][8];
  int          mCPtr[32];

  function automatic void modelReset();
    for (int s = 0; s < 32; s++) begin
      mBV[s] = 0; mCnt[s] = 0; mUPtr[s] = 0; mCPtr[s] = 0;
      for (int u = 0; u < 4; u++) mUVal[s][u] = 0;
      for (int e = 0; e < 8; e++) mCVal[s][e] = 0;
    end
  endfunction

  function automatic void modelPack(int s, logic [30:0] v, logic [18:0] p);
    mCV[s][mCPtr[s]] = v; mCP[s][mCPtr[s]] = p; mCVal[s][mCPtr[s]] = 1;
    mCPtr[s] = (mCPtr[s] + 1) % 8;
  endfunction

  function automatic void modelInsert(logic [30:0] v, logic [18:0] p);
    int s = int'(v[4:0]);
    if (!mBV[s]) begin
      mBV[s] = 1; mVB[s] = v[30:13]; mPB[s] = p[18:9]; mCnt[s] = INIT;
      modelPack(s, v, p);
    end else if (v[30:13] == mVB[s] && p[18:9] == mPB[s]) begin
      modelPack(s, v, p);
    end else begin
      mUV[s][mUPtr[s]] = v; mUP[s][mUPtr[s]] = p; mUVal[s][mUPtr[s]] = 1;
      mUPtr[s] = (mUPtr[s] + 1) % 4;
      mCnt[s]--;
      if (mCnt[s] == 0) begin
        for (int e = 0; e < 8; e++) mCVal[s][e] = 0;
        mCPtr[s] = 0; mBV[s] = 0;
      end
    end
  endfunction

  function automatic logic [19:0] modelLookup(logic [30:0] v);
    int s = int'(v[4:0]);
    for (int u = 0; u < 4; u++)
      if (mUVal[s][u] && mUV[s][u] == v) return {1'b1, mUP[s][u]};
    for (int e = 0; e < 8; e++)
      if (mCVal[s][e] && mCV[s][e] == v) return {1'b1, mCP[s][e]};
    return '0;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; insValid = 1'b0; lookupValid = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    modelReset();
  endtask

  task automatic doInsert(logic [30:0] v, logic [18:0] p);
    @(negedge clk);
    insValid = 1'b1; insVpn = v; insPpn = p;
    @(posedge clk); #1;
    insValid = 1'b0;
    modelInsert(v, p);
  endtask

  task automatic doLookup(logic [30:0] v, string req);
    logic [19:0] exp;
    @(negedge clk);
    lookupValid = 1'b1; lookupVpn = v;
    exp = modelLookup(v);
    @(posedge clk); #1;
    lookupValid = 1'b0;
    @(negedge clk);
    chk(respValid == 1'b1, "R2", "respValid", 32'(respValid), 32'd1);
    chk(respHit == exp[19], req, "hit", 32'(respHit), 32'(exp[19]));
    chk(respPpn == exp[18:0], req, "ppn", 32'(respPpn), 32'(exp[18:0]));
  endtask

  function automatic logic [30:0] mkV(logic [17:0] up, logic [7:0] idx, logic [4:0] set);
    return {up, idx, set};
  endfunction

  function automatic logic [18:0] mkP(logic [9:0] up, logic [8:0] lo);
    return {up, lo};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [17:0] VA, VB2, VC;
    logic [9:0]  PA, PB2;
    logic [30:0] hist[$];
    int seq;
    VA = 18'h01000; VB2 = 18'h02000; VC = 18'h03000;
    PA = 10'h020;   PB2 = 10'h021;
    void'($urandom(32'd4650));
    modelReset();
    doReset();

    // R1: reset state
    @(negedge clk);
    chk(respValid == 1'b0, "R2", "idle respValid", 32'(respValid), 32'd0);
    doLookup(mkV(VA, 0, 3), "R1");

    // R4/R8: nine packed inserts into set 3
    for (int i = 0; i < 9; i++) doInsert(mkV(VA, 8'(i), 3), mkP(PA, 9'(i)));
    doLookup(mkV(VA, 0, 3), "R8");   // evicted by ninth
    doLookup(mkV(VA, 1, 3), "R10");
    doLookup(mkV(VA, 8, 3), "R4");

    // R5: virtual matches, physical does not -> plain half
    doInsert(mkV(VA, 20, 3), mkP(PB2, 9'd20));
    doLookup(mkV(VA, 20, 3), "R5");
    for (int i = 21; i < 24; i++) doInsert(mkV(VB2, 8'(i), 3), mkP(PB2, 9'(i)));
    doLookup(mkV(VA, 1, 3), "R8");   // plain inserts keep packed entries
    doInsert(mkV(VB2, 24, 3), mkP(PB2, 9'd24));
    doLookup(mkV(VA, 20, 3), "R7");  // fifth plain evicts first
    doLookup(mkV(VB2, 21, 3), "R7");

    // R6/R9: countdown boundary (5 plain so far)
    doInsert(mkV(VB2, 25, 3), mkP(PB2, 9'd25));
    doInsert(mkV(VB2, 26, 3), mkP(PB2, 9'd26));
    doLookup(mkV(VA, 1, 3), "R9");   // seventh: still present
    doInsert(mkV(VB2, 27, 3), mkP(PB2, 9'd27));
    doLookup(mkV(VA, 1, 3), "R9");   // eighth: flushed
    doLookup(mkV(VB2, 27, 3), "R6");

    // R9: rebase on next insert
    doInsert(mkV(VB2, 30, 3), mkP(PB2, 9'd30));
    doInsert(mkV(VB2, 31, 3), mkP(PB2, 9'd31));
    doLookup(mkV(VB2, 30, 3), "R9");
    doLookup(mkV(VB2, 31, 3), "R10");

    // R3: another set has its own base
    doInsert(mkV(VC, 0, 4), mkP(PA, 9'd5));
    doLookup(mkV(VC, 0, 4), "R3");
    doLookup(mkV(VB2, 31, 3), "R3");
    doLookup(mkV(VC, 0, 3), "R3");

    // Random phase
    doReset();
    seq = 0;
    for (int n = 0; n < 400; n++) begin
      if (($urandom % 10) < 6 && seq < 250) begin
        logic [17:0] up;
        logic [9:0]  pu;
        logic [30:0] v;
        case ($urandom % 3)
          0: up = 18'h00123;
          1: up = 18'h00124;
          default: up = 18'h2abcd;
        endcase
        pu = ($urandom % 2) ? 10'h011 : 10'h012;
        v = mkV(up, 8'(seq), 5'($urandom % 4));
        seq++;
        hist.push_back(v);
        doInsert(v, mkP(pu, 9'($urandom)));
      end else if (hist.size() > 0 && ($urandom % 4) != 0) begin
        doLookup(hist[$urandom % hist.size()], "R10");
      end else begin
        doLookup(31'($urandom), "R5");
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule